// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block sits on the controller side of an asynchronous DRAM and decides when the memory must be touched for upkeep rather than for data. After reset it waits out the power-on pause. It then asks an access arbiter for a fixed number of dummy row cycles. After that it paces distributed refresh requests, so that every row is refreshed once per retention window. All requests use a request/grant handshake. A request stays raised until the arbiter grants it, and each grant retires exactly one request.

On command the scheduler takes the memory into self refresh. It first asks for a CAS-before-RAS cycle. It then holds its self-refresh control high, telling the access sequencer to keep the row strobe low, for at least the minimum self-refresh strobe time. When an exit is requested after that time, it waits out the precharge time. If the controller used burst or row-only refresh before the low-power state, it then requests a catch-up burst covering every row before normal access resumes. With distributed refresh it returns to normal operation directly.

A ticket counter keeps periodic requests that the arbiter has not yet served. A sticky error flag reports a backlog beyond the allowed depth. All intervals come from the clock frequency in MHz.

States: `S_PAUSE` (power-on wait), `S_INIT` (dummy cycles), `S_RUN` (normal access with paced refresh), `S_SR_ENTRY` (CBR request before the low-power state), `S_SR_HOLD` (self refresh held), `S_SR_EXIT` (precharge wait), `S_CATCHUP` (full-array burst). Transitions:
- PAUSE→INIT when the pause count ends.
- INIT→RUN on the last dummy grant.
- RUN→SR_ENTRY on `sr_enter`.
- SR_ENTRY→SR_HOLD on grant.
- SR_HOLD→SR_EXIT when the minimum hold has passed and `sr_exit` is high.
- SR_EXIT→CATCHUP (if `burst_after_sr`) or SR_EXIT→RUN when the precharge count ends.
- CATCHUP→RUN on the last burst grant.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, `ref_req`, `init_done`, `access_ok`, `sr_ctrl` and `backlog_err` are low. `ref_req` first rises exactly PAUSE_CYC = CLK_MHZ*PAUSE_US cycles after reset release.
- R2: During initialization the block requests dummy cycles with `ref_kind` = 2'b00. After exactly INIT_CYCLES grants, `init_done` and `access_ok` rise together. `init_done` then stays high until reset.
- R3: In normal operation a periodic request (`ref_kind` = 2'b01) is raised every INTERVAL_CYC = CLK_MHZ*WINDOW_US/ROWS cycles, counted from entry to normal operation. A raised request stays high until it is granted.
- R4: Periodic requests that are not granted accumulate, and each grant retires one. `backlog_err` rises on the tick that would take the backlog beyond BACKLOG_MAX and stays high until reset.
- R5: `sr_enter` in normal operation drops `access_ok` and the periodic backlog, and raises a request with `ref_kind` = 2'b10. The grant of that request raises `sr_ctrl`.
- R6: `sr_ctrl` stays high for at least HOLD_CYC = CLK_MHZ*SR_HOLD_US cycles. `sr_exit` before then has no effect.
- R7: After `sr_ctrl` falls, neither `ref_req` nor `access_ok` is high for TRP_CYC = ceil(CLK_MHZ*TRP_NS/1000) cycles.
- R8: With `burst_after_sr` high at the end of the precharge wait, the block issues exactly ROWS requests with `ref_kind` = 2'b11 before `access_ok` returns. With it low, `access_ok` returns directly and the first periodic request follows INTERVAL_CYC cycles later.
- R9: `ref_gnt` while `ref_req` is low has no effect, and `sr_enter` before initialization completes has no effect.
- R10: `sr_ctrl` is never high together with `ref_req` or `access_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Arbiter grant; accepts the current request when `ref_req` is high |
| sr_enter | input | 1 | Command to enter self refresh (acted on in normal operation) |
| sr_exit | input | 1 | Command to leave self refresh (acted on after the minimum hold) |
| burst_after_sr | input | 1 | Controller used burst or row-only refresh; ask for a full catch-up after self refresh |
| ref_req | output | 1 | Request for an upkeep cycle |
| ref_kind | output | 2 | 00 dummy init, 01 periodic, 10 self-refresh entry CBR, 11 catch-up |
| init_done | output | 1 | Initialization finished (sticky) |
| access_ok | output | 1 | Normal data access allowed |
| sr_ctrl | output | 1 | Hold the row strobe low for self refresh |
| backlog_err | output | 1 | Periodic backlog exceeded its limit (sticky) |

## Verification
The grant line is driven in three patterns. With the grant always high, the bench measures the exact refresh period and counts the dummy and catch-up bursts. With the grant held low, it checks that a request is held and that the backlog error appears on the right tick. With the grant released after a backlog, it checks that the queued requests drain one per grant. Self refresh is entered twice, once without and once with the catch-up option, with the exit command raised early. This separates the minimum hold, the precharge wait and the two ways of resuming. A scoreboard of expected request kinds catches any grant taken for the wrong reason. Grants and entry commands given during the power-on pause show that both are ignored there.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

    typedef enum logic [2:0] {
        S_PAUSE    = 3'd0,
        S_INIT     = 3'd1,
        S_RUN      = 3'd2,
        S_SR_ENTRY = 3'd3,
        S_SR_HOLD  = 3'd4,
        S_SR_EXIT  = 3'd5,
        S_CATCHUP  = 3'd6
    } sched_state_t;

    typedef enum logic [1:0] {
        KIND_INIT     = 2'b00,
        KIND_PERIODIC = 2'b01,
        KIND_SR_ENTRY = 2'b10,
        KIND_CATCHUP  = 2'b11
    } req_kind_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/drs_timer.sv
module drs_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end
    end

    // hit marks the last cycle of a span of `limit` counted cycles
    assign hit = (cnt == (limit - W'(1)));

endmodule

// File: rtl/drs_backlog.sv
module drs_backlog #(
    parameter int BACKLOG_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic take,
    output logic has_work,
    output logic err
);
    localparam int PW = $clog2(BACKLOG_MAX + 2);
    localparam logic [PW-1:0] CAP   = PW'(BACKLOG_MAX + 1);
    localparam logic [PW-1:0] LIMIT = PW'(BACKLOG_MAX);

    logic [PW-1:0] pending;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
            err     <= 1'b0;
        end else begin
            if (clr) begin
                pending <= '0;
            end else if (tick && !take) begin
                if (pending != CAP) begin
                    pending <= pending + 1'b1;
                end
            end else if (take && !tick) begin
                pending <= pending - 1'b1;
            end
            if (!clr && tick && !take && (pending >= LIMIT)) begin
                err <= 1'b1;
            end
        end
    end

    assign has_work = (pending != '0);

    // R4: a grant never retires a ticket that does not exist
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !clr) |-> (pending != '0));

    // R4: the overflow flag is sticky
    a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import dram_refresh_pkg::*;
#(
    parameter int CLK_MHZ     = 100,
    parameter int PAUSE_US    = 200,
    parameter int WINDOW_US   = 16000,
    parameter int ROWS        = 1024,
    parameter int INIT_CYCLES = 8,
    parameter int BACKLOG_MAX = 8,
    parameter int SR_HOLD_US  = 100,
    parameter int TRP_NS      = 90
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_gnt,
    input  logic       sr_enter,
    input  logic       sr_exit,
    input  logic       burst_after_sr,
    output logic       ref_req,
    output logic [1:0] ref_kind,
    output logic       init_done,
    output logic       access_ok,
    output logic       sr_ctrl,
    output logic       backlog_err
);
    localparam int PAUSE_CYC    = CLK_MHZ * PAUSE_US;
    localparam int INTERVAL_CYC = (CLK_MHZ * WINDOW_US) / ROWS;
    localparam int HOLD_RAW     = CLK_MHZ * SR_HOLD_US;
    localparam int HOLD_CYC     = (HOLD_RAW < 1) ? 1 : HOLD_RAW;
    localparam int TRP_RAW      = (CLK_MHZ * TRP_NS + 999) / 1000;
    localparam int TRP_CYC      = (TRP_RAW < 1) ? 1 : TRP_RAW;
    localparam int MAXL = imax(imax(PAUSE_CYC, ROWS),
                               imax(imax(HOLD_CYC, TRP_CYC), INIT_CYCLES));
    localparam int TW = $clog2(MAXL + 1);
    localparam int IW = $clog2(INTERVAL_CYC + 1);

    localparam logic [TW-1:0] L_PAUSE = TW'(PAUSE_CYC);
    localparam logic [TW-1:0] L_INIT  = TW'(INIT_CYCLES);
    localparam logic [TW-1:0] L_HOLD  = TW'(HOLD_CYC);
    localparam logic [TW-1:0] L_TRP   = TW'(TRP_CYC);
    localparam logic [TW-1:0] L_ROWS  = TW'(ROWS);
    localparam logic [TW-1:0] L_ONE   = TW'(1);
    localparam logic [IW-1:0] L_IVL   = IW'(INTERVAL_CYC);

    sched_state_t  st, nxt;
    logic          grant;
    logic          t_hit, t_en, t_clr;
    logic [TW-1:0] t_limit;
    logic          in_run, tick, has_work, take;
    logic          done_q;
    req_kind_t     kind;

    assign grant = ref_req && ref_gnt;
    assign in_run = (st == S_RUN);
    assign take   = grant && in_run;

    // phase timer shared by pause, dummy count, hold, precharge and catch-up
    drs_timer #(.W(TW)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (t_clr),
        .en    (t_en),
        .limit (t_limit),
        .hit   (t_hit)
    );

    // refresh pacing, only running in normal operation
    drs_timer #(.W(IW)) u_pace (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!in_run || tick),
        .en    (in_run),
        .limit (L_IVL),
        .hit   (tick_raw)
    );
    logic tick_raw;
    assign tick = in_run && tick_raw;

    drs_backlog #(.BACKLOG_MAX(BACKLOG_MAX)) u_backlog (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!in_run),
        .tick     (tick),
        .take     (take),
        .has_work (has_work),
        .err      (backlog_err)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= S_PAUSE;
            done_q <= 1'b0;
        end else begin
            st <= nxt;
            if (st == S_INIT && nxt == S_RUN) begin
                done_q <= 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        nxt = st;
        unique case (st)
            S_PAUSE:    if (t_hit) nxt = S_INIT;
            S_INIT:     if (grant && t_hit) nxt = S_RUN;
            S_RUN:      if (sr_enter) nxt = S_SR_ENTRY;
            S_SR_ENTRY: if (grant) nxt = S_SR_HOLD;
            S_SR_HOLD:  if (t_hit && sr_exit) nxt = S_SR_EXIT;
            S_SR_EXIT:  if (t_hit) nxt = burst_after_sr ? S_CATCHUP : S_RUN;
            S_CATCHUP:  if (grant && t_hit) nxt = S_RUN;
            default:    nxt = S_PAUSE;
        endcase
    end

    // phase timer control
    assign t_clr = (nxt != st);
    always_comb begin
        t_en    = 1'b0;
        t_limit = L_ONE;
        unique case (st)
            S_PAUSE:   begin t_en = 1'b1;   t_limit = L_PAUSE; end
            S_INIT:    begin t_en = grant;  t_limit = L_INIT;  end
            S_SR_HOLD: begin t_en = !t_hit; t_limit = L_HOLD;  end
            S_SR_EXIT: begin t_en = 1'b1;   t_limit = L_TRP;   end
            S_CATCHUP: begin t_en = grant;  t_limit = L_ROWS;  end
            default:   begin t_en = 1'b0;   t_limit = L_ONE;   end
        endcase
    end

    // outputs
    always_comb begin
        ref_req   = 1'b0;
        kind      = KIND_PERIODIC;
        access_ok = 1'b0;
        sr_ctrl   = 1'b0;
        unique case (st)
            S_PAUSE:    ;
            S_INIT:     begin ref_req = 1'b1; kind = KIND_INIT; end
            S_RUN:      begin ref_req = has_work; access_ok = 1'b1; end
            S_SR_ENTRY: begin ref_req = 1'b1; kind = KIND_SR_ENTRY; end
            S_SR_HOLD:  sr_ctrl = 1'b1;
            S_SR_EXIT:  ;
            S_CATCHUP:  begin ref_req = 1'b1; kind = KIND_CATCHUP; end
            default:    ;
        endcase
    end
    assign ref_kind  = kind;
    assign init_done = done_q;

    // checker support: length of the current self-refresh hold
    int sr_len;
    always_ff @(posedge clk) begin
        if (!rst_n || !sr_ctrl) sr_len <= 0;
        else if (sr_len < HOLD_CYC) sr_len <= sr_len + 1;
    end

    // R1: no data access before initialization has finished
    a_r1_no_access_early: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> (!access_ok && !sr_ctrl));

    // R2: initialization completion is sticky
    a_r2_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R3: a request is held until granted
    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_gnt) |=> ref_req);

    // R6: self refresh is held for the minimum time
    a_r6_hold_min: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sr_ctrl) |-> (sr_len >= HOLD_CYC));

    // R7: quiet in the cycle right after leaving self refresh
    a_r7_quiet_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sr_ctrl) |-> (!ref_req && !access_ok));

    // R10: self refresh excludes requests and access
    a_r10_sr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(sr_ctrl && (ref_req || access_ok)));

endmodule

// File: tb/dram_refresh_sched_tb_top.sv
module dram_refresh_sched_tb_top;
    localparam int CLK_MHZ = 1, PAUSE_US = 20, WINDOW_US = 240, ROWS = 16;
    localparam int INIT_CYCLES = 8, BACKLOG_MAX = 3, SR_HOLD_US = 5, TRP_NS = 3000;
    localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;
    localparam int INTERVAL_CYC = (CLK_MHZ * WINDOW_US) / ROWS;
    localparam int HOLD_CYC = CLK_MHZ * SR_HOLD_US;
    localparam int TRP_CYC = (CLK_MHZ * TRP_NS + 999) / 1000;

    logic clk = 1'b0;
    logic rst_n, ref_gnt, sr_enter, sr_exit, burst_after_sr;
    logic ref_req, init_done, access_ok, sr_ctrl, backlog_err;
    logic [1:0] ref_kind;

    int tests = 0, fails = 0;
    bit done = 1'b0;
    int exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    dram_refresh_sched #(
        .CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .WINDOW_US(WINDOW_US), .ROWS(ROWS),
        .INIT_CYCLES(INIT_CYCLES), .BACKLOG_MAX(BACKLOG_MAX),
        .SR_HOLD_US(SR_HOLD_US), .TRP_NS(TRP_NS)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .sr_enter(sr_enter),
        .sr_exit(sr_exit), .burst_after_sr(burst_after_sr), .ref_req(ref_req),
        .ref_kind(ref_kind), .init_done(init_done), .access_ok(access_ok),
        .sr_ctrl(sr_ctrl), .backlog_err(backlog_err)
    );

    task automatic chk(input string req, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic push(input int kind, input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(kind);
            tag_q.push_back(tag);
        end
    endtask

    // monitor: every accepted request is compared with the expected kind
    always @(negedge clk) begin
        if (rst_n === 1'b1 && ref_req && ref_gnt) begin
            if (exp_q.size() == 0) begin
                chk("R9 unexpected grant", int'(ref_kind), -1);
            end else begin
                chk({tag_q.pop_front(), " kind"}, int'(ref_kind), exp_q.pop_front());
            end
        end
        if (rst_n === 1'b1 && sr_ctrl && (ref_req || access_ok)) begin
            chk("R10 sr_ctrl exclusive", 1, 0);
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic sig(input int which);
        case (which)
            0: return ref_req;
            1: return init_done;
            2: return backlog_err;
            3: return access_ok;
            default: return sr_ctrl;
        endcase
    endfunction

    task automatic count_until(input int which, input logic val, output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (sig(which) != val && n < 400);
    endtask

    task automatic run_all();
        int n;
        rst_n = 1'b0; ref_gnt = 1'b1; sr_enter = 1'b1; sr_exit = 1'b0; burst_after_sr = 1'b0;
        repeat (3) step();
        chk("R1 reset ref_req", ref_req, 0);
        chk("R1 reset init_done", init_done, 0);
        chk("R1 reset access_ok", access_ok, 0);
        chk("R1 reset sr_ctrl/err", sr_ctrl | backlog_err, 0);
        push(0, "R2 init", INIT_CYCLES);
        rst_n = 1'b1;
        // grant and self-refresh command held during the pause (R9)
        count_until(0, 1'b1, n);
        chk("R1 pause length", n, PAUSE_CYC);
        chk("R9 sr_enter ignored before init", int'(ref_kind), 0);
        sr_enter = 1'b0;
        count_until(1, 1'b1, n);
        chk("R2 dummy cycles", n, INIT_CYCLES);
        chk("R2 access_ok with init_done", access_ok, 1);
        push(1, "R3 periodic", 1);
        count_until(0, 1'b1, n);
        chk("R3 first interval", n, INTERVAL_CYC);
        count_until(0, 1'b1, n);
        chk("R3 interval with idle grant R9", n, INTERVAL_CYC);
        ref_gnt = 1'b0;
        count_until(2, 1'b1, n);
        chk("R4 backlog error tick", n, (BACKLOG_MAX) * INTERVAL_CYC);
        chk("R3 request held", ref_req, 1);
        push(1, "R4 drain", BACKLOG_MAX + 1);
        ref_gnt = 1'b1;
        count_until(0, 1'b0, n);
        chk("R4 one ticket per grant", n, BACKLOG_MAX + 1);
        chk("R4 error sticky", backlog_err, 1);
        // self refresh without catch-up
        sr_enter = 1'b1; ref_gnt = 1'b0; sr_exit = 1'b1; burst_after_sr = 1'b0;
        push(2, "R5 entry", 1);
        step();
        chk("R5 entry request", ref_req, 1);
        chk("R5 entry kind", int'(ref_kind), 2);
        chk("R5 access dropped", access_ok, 0);
        ref_gnt = 1'b1; sr_enter = 1'b0;
        step();
        chk("R5 sr_ctrl on grant", sr_ctrl, 1);
        count_until(4, 1'b0, n);
        chk("R6 hold length with early exit", n, HOLD_CYC);
        count_until(3, 1'b1, n);
        chk("R7 precharge before access", n, TRP_CYC);
        chk("R8 no catch-up request", ref_req, 0);
        push(1, "R8 periodic resume", 1);
        count_until(0, 1'b1, n);
        chk("R8 first periodic after resume", n, INTERVAL_CYC);
        // self refresh with catch-up
        sr_enter = 1'b1; burst_after_sr = 1'b1;
        push(2, "R5 entry", 1);
        step();
        chk("R5 entry kind again", int'(ref_kind), 2);
        sr_enter = 1'b0;
        step();
        chk("R5 sr_ctrl again", sr_ctrl, 1);
        count_until(4, 1'b0, n);
        chk("R6 hold length again", n, HOLD_CYC);
        push(3, "R8 catch-up", ROWS);
        count_until(0, 1'b1, n);
        chk("R7 precharge before catch-up", n, TRP_CYC);
        chk("R8 no access during catch-up", access_ok, 0);
        count_until(3, 1'b1, n);
        chk("R8 catch-up length", n, ROWS);
        step();
        chk("R8 all expected grants seen", exp_q.size(), 0);
    endtask

    initial begin
        fork
            begin
                run_all();
                done = 1'b1;
            end
            begin
                int cyc = 0;
                while (!done && cyc < 20000) begin
                    @(posedge clk);
                    cyc++;
                end
                if (!done) begin
                    tests++;
                    fails++;
                    $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
                end
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule